// File: doc/BRIEF.md
# GPIO Bank with Level and Edge Interrupt Sensing

This block is a bank of general-purpose pins driven through a 32-bit register port. Software can drive each pin through an output latch with its own enable, and it can read the pin levels after they pass a two-flop synchronizer. Each pin can raise an interrupt in two ways. Level sensing compares the pin with a polarity bit and does not latch. Edge sensing sets a sticky event bit on the selected edge, and software clears that bit by writing 1 to it. Each kind of source has its own mask.

The unmasked sources of all pins are ORed into one read-only summary bit. A separate summary block holds this bit together with an enable bit. The shared `irq` line is high when both bits are 1.

Register requests arrive on a valid/ready request channel. Every accepted request produces exactly one response beat on a valid/ready response channel, and a write returns zero data. A new request is accepted only when the response slot is empty or is being drained in the same cycle. A response held under back-pressure keeps its data unchanged. Address bit 6 selects the summary block (1) or the pin block (0). Bits 5:0 are the byte offset inside the selected block.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads zero and `pin_out`, `pin_oe` and `irq` are 0.
- R2: `req_ready` = !`rsp_valid` || `rsp_ready`. Each accepted request yields one response in the following cycle, in request order. A write response carries 0. While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_rdata` holds steady.
- R3: Writing offset 0x04 (pin block) sets `pin_out`. Writing 0x08 sets `pin_oe`. Both registers read back what was written.
- R4: Offset 0x00 returns the pin levels after a two-flop synchronizer. A change on `pin_in` is visible to a request accepted three or more rising edges later.
- R5: The level source of a pin is (synchronized pin XOR polarity bit at 0x10) AND mask bit at 0x14. Polarity 0 means active high and 1 means active low. The source is not latched and drops when the pin condition ends.
- R6: The edge select register at 0x24 picks the edge per pin: 0 for rising, 1 for falling. The selected edge sets the sticky event bit at 0x18. The opposite edge does not.
- R7: Writing 1 to a bit of 0x18 clears that event bit. Writing 0 leaves it unchanged.
- R8: If an edge sets an event bit in the same cycle that a write of 1 clears it, the bit stays set.
- R9: The summary status bit 0 at 0x60 equals the OR over all pins of (level source OR (event AND event mask at 0x1C)), and writes to it are ignored. `irq` = status bit 0 AND enable bit 0 at 0x64.
- R10: Bits at or above NUM_PINS, and any unmapped offset, read as zero. Writes to unmapped offsets change nothing.
- R11: Event bits latch whether or not their event mask bit is set. The mask only gates the pending source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Raw pin levels (asynchronous) |
| pin_out | output | NUM_PINS | Output data latch |
| pin_oe | output | NUM_PINS | Output enable per pin |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Bit 6 block select, bits 5:0 byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| irq | output | 1 | Shared interrupt line |

## Verification
Two functions can meet in one cycle: an edge latching an event bit, and a write-1-to-clear of that same bit. The bench provokes this by changing a pin and then issuing the clearing write, timed so that the write is accepted on the third rising edge after the change. That is the edge on which the synchronized transition sets the event. A later read must return the bit set. The bench also runs reads under response back-pressure so that register traffic overlaps stalled responses, and it checks that data are held and responses stay in order.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int BUS_W   = 32;
  localparam int ADDR_W  = 7;
  localparam int OFS_W   = 6;
  localparam int BLK_BIT = ADDR_W - 1;

  // pin block offsets
  localparam logic [OFS_W-1:0] OFS_PIN_IN   = 6'h00;
  localparam logic [OFS_W-1:0] OFS_PIN_OUT  = 6'h04;
  localparam logic [OFS_W-1:0] OFS_PIN_OE   = 6'h08;
  localparam logic [OFS_W-1:0] OFS_LVL_POL  = 6'h10;
  localparam logic [OFS_W-1:0] OFS_LVL_MSK  = 6'h14;
  localparam logic [OFS_W-1:0] OFS_EVT      = 6'h18;
  localparam logic [OFS_W-1:0] OFS_EVT_MSK  = 6'h1C;
  localparam logic [OFS_W-1:0] OFS_EDGE_SEL = 6'h24;
  // summary block offsets
  localparam logic [OFS_W-1:0] OFS_SUM_STAT = 6'h20;
  localparam logic [OFS_W-1:0] OFS_SUM_EN   = 6'h24;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic rise,
  output logic fall
);
  logic meta, stab, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      stab <= 1'b0;
      prev <= 1'b0;
    end else begin
      meta <= d;
      stab <= meta;
      prev <= stab;
    end
  end

  assign q    = stab;
  assign rise = stab & ~prev;
  assign fall = ~stab & prev;
endmodule

// File: rtl/gpio_edge_latch.sv
module gpio_edge_latch #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rise,
  input  logic [WIDTH-1:0] fall,
  input  logic [WIDTH-1:0] edge_sel,
  input  logic [WIDTH-1:0] clr,
  output logic [WIDTH-1:0] evt
);
  logic [WIDTH-1:0] hit;

  // sel 0 -> rising, 1 -> falling
  assign hit = (~edge_sel & rise) | (edge_sel & fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt <= '0;
    else        evt <= (evt & ~clr) | hit;  // a fresh edge beats the clear
  end
endmodule

// File: rtl/gpio_bus_port.sv
module gpio_bus_port #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [DW-1:0] rd_word,
  output logic          req_ready,
  output logic          fire,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata
);
  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [BUS_W-1:0]    req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [BUS_W-1:0]    rsp_rdata,
  output logic                irq
);
  localparam int NP = NUM_PINS;

  logic             fire, wr_fire, sum_blk;
  logic [OFS_W-1:0] ofs;
  logic [BUS_W-1:0] rd_word;
  logic [NP-1:0]    pin_sync, rise, fall;
  logic [NP-1:0]    lvl_pol, lvl_msk, evt_msk, edge_sel, evt, evt_clr;
  logic [NP-1:0]    lvl_src, edge_src, pin_src;
  logic             irq_en, src_any;
  logic             wr_out, wr_oe, wr_lpol, wr_lmsk, wr_evt, wr_emsk, wr_esel, wr_en;

  gpio_bus_port #(.DW(BUS_W)) u_port (
    .clk, .rst_n, .req_valid, .req_write, .rd_word,
    .req_ready, .fire, .rsp_valid, .rsp_ready, .rsp_rdata
  );

  for (genvar i = 0; i < NP; i++) begin : g_sync
    gpio_pin_sync u_sync (
      .clk, .rst_n, .d(pin_in[i]), .q(pin_sync[i]), .rise(rise[i]), .fall(fall[i])
    );
  end

  assign sum_blk = req_addr[BLK_BIT];
  assign ofs     = req_addr[OFS_W-1:0];
  assign wr_fire = fire && req_write;

  always_comb begin
    wr_out  = wr_fire && !sum_blk && ofs == OFS_PIN_OUT;
    wr_oe   = wr_fire && !sum_blk && ofs == OFS_PIN_OE;
    wr_lpol = wr_fire && !sum_blk && ofs == OFS_LVL_POL;
    wr_lmsk = wr_fire && !sum_blk && ofs == OFS_LVL_MSK;
    wr_evt  = wr_fire && !sum_blk && ofs == OFS_EVT;
    wr_emsk = wr_fire && !sum_blk && ofs == OFS_EVT_MSK;
    wr_esel = wr_fire && !sum_blk && ofs == OFS_EDGE_SEL;
    wr_en   = wr_fire &&  sum_blk && ofs == OFS_SUM_EN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_out  <= '0;
      pin_oe   <= '0;
      lvl_pol  <= '0;
      lvl_msk  <= '0;
      evt_msk  <= '0;
      edge_sel <= '0;
      irq_en   <= 1'b0;
    end else begin
      if (wr_out)  pin_out  <= req_wdata[NP-1:0];
      if (wr_oe)   pin_oe   <= req_wdata[NP-1:0];
      if (wr_lpol) lvl_pol  <= req_wdata[NP-1:0];
      if (wr_lmsk) lvl_msk  <= req_wdata[NP-1:0];
      if (wr_emsk) evt_msk  <= req_wdata[NP-1:0];
      if (wr_esel) edge_sel <= req_wdata[NP-1:0];
      if (wr_en)   irq_en   <= req_wdata[0];
    end
  end

  assign evt_clr = wr_evt ? req_wdata[NP-1:0] : '0;

  gpio_edge_latch #(.WIDTH(NP)) u_evt (
    .clk, .rst_n, .rise, .fall, .edge_sel, .clr(evt_clr), .evt
  );

  assign lvl_src  = (pin_sync ^ lvl_pol) & lvl_msk;
  assign edge_src = evt & evt_msk;
  assign pin_src  = lvl_src | edge_src;
  assign src_any  = |pin_src;
  assign irq      = src_any & irq_en;

  always_comb begin
    rd_word = '0;
    if (!sum_blk) begin
      case (ofs)
        OFS_PIN_IN:   rd_word[NP-1:0] = pin_sync;
        OFS_PIN_OUT:  rd_word[NP-1:0] = pin_out;
        OFS_PIN_OE:   rd_word[NP-1:0] = pin_oe;
        OFS_LVL_POL:  rd_word[NP-1:0] = lvl_pol;
        OFS_LVL_MSK:  rd_word[NP-1:0] = lvl_msk;
        OFS_EVT:      rd_word[NP-1:0] = evt;
        OFS_EVT_MSK:  rd_word[NP-1:0] = evt_msk;
        OFS_EDGE_SEL: rd_word[NP-1:0] = edge_sel;
        default:      rd_word = '0;
      endcase
    end else begin
      case (ofs)
        OFS_SUM_STAT: rd_word[0] = src_any;
        OFS_SUM_EN:   rd_word[0] = irq_en;
        default:      rd_word = '0;
      endcase
    end
  end
endmodule

module gpio_irq_bank_chk #(
  parameter int NP = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [31:0]   rsp_rdata,
  input logic          irq,
  input logic          irq_en,
  input logic [NP-1:0] pin_out,
  input logic [NP-1:0] pin_oe,
  input logic [NP-1:0] evt
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_out == '0 && pin_oe == '0 && !irq));

  p_rsp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_no_accept_stalled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_one_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_evt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && req_write) |=> (($past(evt) & ~evt) == '0));

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NP(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .irq(irq), .irq_en(irq_en), .pin_out(pin_out),
  .pin_oe(pin_oe), .evt(evt)
);

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;
  localparam int NP = 24;
  localparam logic [6:0] A_IN = 7'h00, A_OUT = 7'h04, A_OE = 7'h08, A_LPOL = 7'h10,
    A_LMSK = 7'h14, A_EVT = 7'h18, A_EMSK = 7'h1C, A_ESEL = 7'h24,
    A_STAT = 7'h60, A_EN = 7'h64, A_HOLE = 7'h0C, A_HOLE2 = 7'h28;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic req_valid = 1'b0, req_write = 1'b0, req_ready;
  logic [6:0] req_addr = '0;
  logic [31:0] req_wdata = '0, rsp_rdata;
  logic rsp_valid, rsp_ready = 1'b1, irq;
  logic bp = 1'b0;
  int unsigned cyc = 0;
  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic held = 1'b0;
  logic [31:0] held_d = '0;

  always #10 clk = ~clk;

  gpio_irq_bank #(.NUM_PINS(NP)) u_dut (
    .clk, .rst_n, .pin_in, .pin_out, .pin_oe, .req_valid, .req_ready, .req_write,
    .req_addr, .req_wdata, .rsp_valid, .rsp_ready, .rsp_rdata, .irq
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2 rsp_ready = bp ? cyc[0] : 1'b1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (held) check(rsp_rdata == held_d, "R2 held response data", rsp_rdata, held_d);
      held   = rsp_valid && !rsp_ready;
      held_d = rsp_rdata;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R2 unexpected response", rsp_rdata, 32'h0);
        else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rsp_rdata == e, t, rsp_rdata, e);
        end
      end
    end
  end

  task automatic xfer(input bit wr, input logic [6:0] a, input logic [31:0] d,
                      input logic [31:0] e, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    exp_q.push_back(wr ? 32'h0 : e);
    tag_q.push_back(wr ? "R2 write response" : tag);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    xfer(1'b1, a, d, 32'h0, "");
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] e, input string tag);
    xfer(1'b0, a, 32'h0, e, tag);
  endtask

  task automatic set_pins(input logic [NP-1:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(posedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    check(irq == e, tag, {31'h0, irq}, {31'h0, e});
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    check(pin_out == '0, "R1 pin_out", 32'(pin_out), 32'h0);
    check(pin_oe == '0, "R1 pin_oe", 32'(pin_oe), 32'h0);
    check(irq == 1'b0, "R1 irq", {31'h0, irq}, 32'h0);
    rd(A_OUT, 0, "R1 out reg"); rd(A_OE, 0, "R1 oe reg"); rd(A_LPOL, 0, "R1 lpol");
    rd(A_LMSK, 0, "R1 lmsk"); rd(A_EVT, 0, "R1 evt"); rd(A_EMSK, 0, "R1 emsk");
    rd(A_ESEL, 0, "R1 esel"); rd(A_STAT, 0, "R1 status"); rd(A_EN, 0, "R1 enable");

    // R3 output latch and enable
    wr(A_OUT, 32'h0012_3456);
    wr(A_OE, 32'h00FF_00FF);
    @(negedge clk);
    check(32'(pin_out) == 32'h0012_3456, "R3 pin_out", 32'(pin_out), 32'h0012_3456);
    check(32'(pin_oe) == 32'h00FF_00FF, "R3 pin_oe", 32'(pin_oe), 32'h00FF_00FF);
    rd(A_OUT, 32'h0012_3456, "R3 out readback");
    rd(A_OE, 32'h00FF_00FF, "R3 oe readback");

    // R10 unimplemented bits and holes
    wr(A_OUT, 32'hFFFF_FFFF);
    rd(A_OUT, 32'h00FF_FFFF, "R10 upper bits zero");
    wr(A_HOLE, 32'hFFFF_FFFF);
    rd(A_HOLE, 0, "R10 hole reads zero");
    rd(A_HOLE2, 0, "R10 second hole");
    rd(A_OE, 32'h00FF_00FF, "R10 hole write harmless");

    // R4 input sample, R6/R11 rising events latch with mask clear
    set_pins(24'hA5_5A3C);
    rd(A_IN, 32'h00A5_5A3C, "R4 input sample");
    rd(A_EVT, 32'h00A5_5A3C, "R11 events latched unmasked");
    chk_irq(1'b0, "R11 masked event no irq");
    set_pins(24'h0);
    rd(A_IN, 32'h0, "R4 input low");
    rd(A_EVT, 32'h00A5_5A3C, "R6 falling ignored when rising selected");
    wr(A_EVT, 32'h0000_5A3C);
    rd(A_EVT, 32'h00A5_0000, "R7 partial clear");
    wr(A_EVT, 32'hFFFF_FFFF);
    rd(A_EVT, 0, "R7 full clear");

    // R5 level sensing, R9 summary
    wr(A_EN, 1);
    wr(A_LMSK, 1);
    chk_irq(1'b0, "R5 pin low active-high idle");
    set_pins(24'h1);
    chk_irq(1'b1, "R5 level high raises");
    rd(A_STAT, 1, "R9 status set");
    wr(A_STAT, 0);
    rd(A_STAT, 1, "R9 status read-only");
    wr(A_EN, 0);
    chk_irq(1'b0, "R9 enable gates irq");
    wr(A_EN, 1);
    chk_irq(1'b1, "R9 enable restores irq");
    set_pins(24'h0);
    chk_irq(1'b0, "R5 level not latched");
    wr(A_LPOL, 1);
    chk_irq(1'b1, "R5 active-low polarity");
    wr(A_LMSK, 0);
    chk_irq(1'b0, "R5 level mask");
    wr(A_LPOL, 0);
    wr(A_EVT, 32'hFFFF_FFFF);

    // R6/R7 edge sensing
    wr(A_EMSK, 32'h8);
    set_pins(24'h8);
    chk_irq(1'b1, "R6 rising event irq");
    wr(A_EVT, 32'h8);
    chk_irq(1'b0, "R7 clear drops irq");
    set_pins(24'h0);
    chk_irq(1'b0, "R6 falling ignored");
    wr(A_ESEL, 32'h8);
    set_pins(24'h8);
    chk_irq(1'b0, "R6 rising ignored when falling selected");
    set_pins(24'h0);
    chk_irq(1'b1, "R6 falling event irq");
    rd(A_EVT, 32'h8, "R6 falling event bit");
    wr(A_EVT, 32'h0);
    chk_irq(1'b1, "R7 zero write keeps event");
    wr(A_EVT, 32'h8);
    chk_irq(1'b0, "R7 cleared");
    wait_idle();

    // R8 set beats clear in the same cycle (pin 5, rising)
    @(negedge clk);
    pin_in = 24'h20;
    @(negedge clk);
    wr(A_EVT, 32'h20);
    rd(A_EVT, 32'h20, "R8 set wins over clear");
    wr(A_EVT, 32'h20);
    rd(A_EVT, 32'h0, "R7 later clear works");

    // R2 back-pressure
    bp = 1'b1;
    rd(A_OUT, 32'h00FF_FFFF, "R2 bp read out");
    rd(A_OE, 32'h00FF_00FF, "R2 bp read oe");
    wr(A_LPOL, 32'h0000_0F0F);
    rd(A_LPOL, 32'h0000_0F0F, "R2 bp read lpol");
    rd(A_ESEL, 32'h8, "R2 bp read esel");
    wait_idle();
    bp = 1'b0;
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 all responses returned", exp_q.size(), 0);
    finish_run();
  end
endmodule